// File: doc/BRIEF.md
# Range-Based Cache Maintenance Engine

This block is the maintenance sequencer of a set-associative data cache. It walks every tag entry and, for each valid line whose line address falls inside a programmed inclusive range, cleans it (writes it back if dirty, then marks it clean), invalidates it, or does both. Range commands run in the background: the engine uses the tag port only in cycles when normal cache traffic leaves it free. When a dirty line must be written back, the engine hands the request to the write-back datapath and waits for completion before it moves on.

The engine also runs a full invalidate. This happens by itself when reset is released and again on a software request. While it runs, the full-busy output tells the cache to hold back cacheable requests, and the engine clears one tag entry per cycle without regard to traffic. Three sticky flags cover the end of a full invalidate, the end of a range command, and a write-back error. Each flag has its own clear pulse and its own enable, and the enabled flags are ORed onto one interrupt line.

Top module: `cmaint_engine`

## Requirements
- R1: When reset is released, a full invalidate runs at once. full_busy_o is 1 from reset onward, every entry receives an invalidate strobe, and then full_busy_o falls in the same cycle that full_end_o rises.
- R2: A start pulse is accepted only when en_i is 1, the engine is idle (no full invalidate and no range command busy), and the code register holds 3'b001, 3'b010 or 3'b011. cmd_busy_o rises on the next clock. Otherwise the pulse has no effect.
- R3: A line matches when valid and rng_lo_i <= {tag, set index} <= rng_hi_i, both bounds inclusive and given in 16-byte line units (byte address bits [ADDR_W-1:4]). If rng_lo_i > rng_hi_i, no line matches.
- R4: Code 3'b001 (clean): each matching dirty line produces one write-back request at byte address {tag, set, 4'b0}, with the way and the line's privilege bit. The line's dirty bit is then cleared and its valid bit is kept. Clean matching lines are left as they are.
- R5: Code 3'b010 (invalidate): every matching line has its valid, dirty and privilege bits cleared, and no write-back request is made.
- R6: Code 3'b011 (clean and invalidate): matching dirty lines are written back as in R4, and all matching lines then end invalid.
- R7: During a range command, tag_acc_o is never 1 in a cycle where tag_busy_i is 1.
- R8: After the last entry has been visited, cmd_busy_o falls in the same cycle that cmd_end_o rises.
- R9: A finv_i pulse with en_i = 1 while the engine is idle starts a full invalidate that clears every entry, with full_busy_o high throughout. A full invalidate and a range command never run together.
- R10: err_o is set by a write-back completion that reports an error (wb_done_i and wb_err_i with a request pending) or by an evict_err_i pulse.
- R11: clr_err_i, clr_fend_i and clr_cend_i each clear their own flag (a set in the same cycle wins). irq_o is (err_o & ie_err_i) | (full_end_o & ie_fend_i) | (cmd_end_o & ie_cend_i).
- R12: A code write (code_wr_i) is taken only while cmd_busy_o is 0. A write made while busy is ignored, and code_o shows the code that is held.
- R13: While a write-back request is pending, wb_req_o stays high until wb_done_i, and the engine makes no tag access and does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Cache enable; gates command acceptance |
| code_wr_i | input | 1 | Write strobe for the command code |
| code_wdata_i | input | 3 | Command code to write |
| start_i | input | 1 | Start pulse for a range command |
| finv_i | input | 1 | Full invalidate request pulse |
| rng_lo_i | input | ADDR_W-4 | Inclusive range start, line units |
| rng_hi_i | input | ADDR_W-4 | Inclusive range end, line units |
| tag_busy_i | input | 1 | Tag port in use by normal traffic this cycle |
| tag_rd_valid_i | input | 1 | Valid bit of the addressed entry |
| tag_rd_dirty_i | input | 1 | Dirty bit of the addressed entry |
| tag_rd_priv_i | input | 1 | Privilege bit of the addressed entry |
| tag_rd_tag_i | input | TAG_W | Tag of the addressed entry |
| tag_acc_o | output | 1 | Engine owns the tag port this cycle |
| tag_set_o | output | SET_W | Set index addressed |
| tag_way_o | output | WAY_W | Way addressed |
| tag_inv_o | output | 1 | Clear valid, dirty and privilege of the entry |
| tag_cln_o | output | 1 | Clear dirty bit of the entry |
| wb_req_o | output | 1 | Write-back request, held until done |
| wb_addr_o | output | ADDR_W | Line byte address to write back |
| wb_way_o | output | WAY_W | Way of the line to write back |
| wb_priv_o | output | 1 | Privilege attribute for the write-back |
| wb_done_i | input | 1 | Write-back finished |
| wb_err_i | input | 1 | Write-back finished with an error |
| evict_err_i | input | 1 | Error on an eviction write-back |
| clr_err_i | input | 1 | Clear error flag |
| clr_fend_i | input | 1 | Clear full-invalidate end flag |
| clr_cend_i | input | 1 | Clear command end flag |
| ie_err_i | input | 1 | Interrupt enable for the error flag |
| ie_fend_i | input | 1 | Interrupt enable for the full-invalidate end flag |
| ie_cend_i | input | 1 | Interrupt enable for the command end flag |
| code_o | output | 3 | Held command code |
| full_busy_o | output | 1 | Full invalidate running; cacheable requests must wait |
| full_end_o | output | 1 | Full invalidate finished flag |
| cmd_busy_o | output | 1 | Range command running |
| cmd_end_o | output | 1 | Range command finished flag |
| err_o | output | 1 | Write-back error flag |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench builds the engine with 8 sets of 2 ways on a 32-bit address, which gives 16 tag entries. Each walk is therefore a few dozen cycles, and every entry's final state can be checked after each command. With small tag values all line addresses lie between 0 and 63, so ranges that cover everything, part of the cache, a single narrow band, or nothing (start above end) all hit lines that are really present. The same size keeps the walk short enough that traffic holding the tag port one cycle in two or three in four can be mixed in, along with write-backs that complete with an error.

// File: rtl/cme_pkg.sv
package cme_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_FINV   = 3'd1,
    ST_WALK   = 3'd2,
    ST_WBWAIT = 3'd3,
    ST_WBUPD  = 3'd4
  } cme_state_e;

  localparam logic [2:0] CODE_NOP   = 3'b000;
  localparam logic [2:0] CODE_CLEAN = 3'b001;
  localparam logic [2:0] CODE_INV   = 3'b010;
  localparam logic [2:0] CODE_BOTH  = 3'b011;

  function automatic logic code_is_cmd(input logic [2:0] c);
    return (c == CODE_CLEAN) || (c == CODE_INV) || (c == CODE_BOTH);
  endfunction

endpackage

// File: rtl/cme_range_match.sv
module cme_range_match #(
  parameter int LA_W = 28
) (
  input  logic [LA_W-1:0] lo_i,
  input  logic [LA_W-1:0] hi_i,
  input  logic [LA_W-1:0] line_i,
  output logic            in_rng_o
);

  logic ge_lo;
  logic le_hi;

  always_comb begin
    ge_lo    = (line_i >= lo_i);
    le_hi    = (line_i <= hi_i);
    in_rng_o = ge_lo && le_hi;
  end

endmodule

// File: rtl/cme_walk_ctrl.sv
module cme_walk_ctrl
  import cme_pkg::*;
#(
  parameter int SET_W = 7,
  parameter int WAY_W = 1,
  parameter int TAG_W = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             start_i,
  input  logic             finv_i,
  input  logic             code_ok_i,
  input  logic             do_clean_i,
  input  logic             do_inv_i,
  input  logic             tag_busy_i,
  input  logic             rd_valid_i,
  input  logic             rd_dirty_i,
  input  logic             rd_priv_i,
  input  logic [TAG_W-1:0] rd_tag_i,
  input  logic             in_rng_i,
  input  logic             wb_done_i,
  output logic             tag_acc_o,
  output logic             tag_inv_o,
  output logic             tag_cln_o,
  output logic [SET_W-1:0] tag_set_o,
  output logic [WAY_W-1:0] tag_way_o,
  output logic             wb_req_o,
  output logic [TAG_W-1:0] wb_tag_o,
  output logic             wb_priv_o,
  output logic             full_busy_o,
  output logic             cmd_busy_o,
  output logic             fend_o,
  output logic             cend_o
);

  localparam int IDX_W = SET_W + WAY_W;

  cme_state_e       st_q, st_d;
  logic [IDX_W-1:0] cnt_q, cnt_d;
  logic             cnt_en, cnt_clr;
  logic [TAG_W-1:0] wtag_q;
  logic             wpriv_q;
  logic             wlat_en;
  logic             last, hit, need_wb, idle, finv_ok, start_ok;

  always_comb begin
    idle     = (st_q == ST_IDLE);
    last     = (cnt_q == {IDX_W{1'b1}});
    hit      = rd_valid_i && in_rng_i;
    need_wb  = hit && do_clean_i && rd_dirty_i;
    finv_ok  = finv_i && en_i && idle;
    start_ok = start_i && en_i && idle && code_ok_i && !finv_ok;
  end

  always_comb begin
    st_d      = st_q;
    cnt_en    = 1'b0;
    cnt_clr   = 1'b0;
    wlat_en   = 1'b0;
    tag_acc_o = 1'b0;
    tag_inv_o = 1'b0;
    tag_cln_o = 1'b0;
    fend_o    = 1'b0;
    cend_o    = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (finv_ok) begin
          st_d    = ST_FINV;
          cnt_clr = 1'b1;
        end else if (start_ok) begin
          st_d    = ST_WALK;
          cnt_clr = 1'b1;
        end
      end
      ST_FINV: begin
        tag_acc_o = 1'b1;
        tag_inv_o = 1'b1;
        cnt_en    = 1'b1;
        if (last) begin
          st_d   = ST_IDLE;
          fend_o = 1'b1;
        end
      end
      ST_WALK: begin
        if (!tag_busy_i) begin
          tag_acc_o = 1'b1;
          if (need_wb) begin
            st_d    = ST_WBWAIT;
            wlat_en = 1'b1;
          end else begin
            tag_inv_o = hit && do_inv_i;
            cnt_en    = 1'b1;
            if (last) begin
              st_d   = ST_IDLE;
              cend_o = 1'b1;
            end
          end
        end
      end
      ST_WBWAIT: begin
        if (wb_done_i) st_d = ST_WBUPD;
      end
      ST_WBUPD: begin
        if (!tag_busy_i) begin
          tag_acc_o = 1'b1;
          tag_cln_o = 1'b1;
          tag_inv_o = do_inv_i;
          cnt_en    = 1'b1;
          if (last) begin
            st_d   = ST_IDLE;
            cend_o = 1'b1;
          end else begin
            st_d = ST_WALK;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
    cnt_d = cnt_clr ? '0 : cnt_q + IDX_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_FINV;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (cnt_en || cnt_clr) cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wtag_q  <= '0;
      wpriv_q <= 1'b0;
    end else if (wlat_en) begin
      wtag_q  <= rd_tag_i;
      wpriv_q <= rd_priv_i;
    end
  end

  assign tag_set_o   = cnt_q[IDX_W-1:WAY_W];
  assign tag_way_o   = cnt_q[WAY_W-1:0];
  assign wb_req_o    = (st_q == ST_WBWAIT);
  assign wb_tag_o    = wtag_q;
  assign wb_priv_o   = wpriv_q;
  assign full_busy_o = (st_q == ST_FINV);
  assign cmd_busy_o  = (st_q == ST_WALK) || (st_q == ST_WBWAIT) || (st_q == ST_WBUPD);

  // R13: a pending write-back is held until it completes
  assert_wb_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_req_o && !wb_done_i) |=> wb_req_o);

  // R13: no tag access while the write-back is outstanding
  assert_no_acc_wait_R13: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req_o |-> !tag_acc_o);

  // R9: full invalidate and range walk are exclusive
  assert_busy_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(full_busy_o && cmd_busy_o));

  // R2: a range command only begins after an enabled start pulse
  assert_start_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_busy_o) |-> $past(start_i && en_i && code_ok_i));

endmodule

// File: rtl/cme_status.sv
module cme_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       code_wr_i,
  input  logic [2:0] code_wdata_i,
  input  logic       cmd_busy_i,
  input  logic       fend_set_i,
  input  logic       cend_set_i,
  input  logic       err_set_i,
  input  logic       clr_err_i,
  input  logic       clr_fend_i,
  input  logic       clr_cend_i,
  input  logic       ie_err_i,
  input  logic       ie_fend_i,
  input  logic       ie_cend_i,
  output logic [2:0] code_o,
  output logic       full_end_o,
  output logic       cmd_end_o,
  output logic       err_o,
  output logic       irq_o
);

  logic [2:0] code_q;
  logic       fend_q, fend_d;
  logic       cend_q, cend_d;
  logic       err_q, err_d;
  logic       code_en;

  always_comb begin
    code_en = code_wr_i && !cmd_busy_i;
    fend_d  = fend_set_i || (fend_q && !clr_fend_i);
    cend_d  = cend_set_i || (cend_q && !clr_cend_i);
    err_d   = err_set_i  || (err_q  && !clr_err_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= 3'b000;
      fend_q <= 1'b0;
      cend_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (code_en) code_q <= code_wdata_i;
      fend_q <= fend_d;
      cend_q <= cend_d;
      err_q  <= err_d;
    end
  end

  assign code_o     = code_q;
  assign full_end_o = fend_q;
  assign cmd_end_o  = cend_q;
  assign err_o      = err_q;
  assign irq_o      = (err_q && ie_err_i) || (fend_q && ie_fend_i) || (cend_q && ie_cend_i);

  // R12: the code register holds while a range command was busy
  assert_code_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmd_busy_i) |-> (code_q == $past(code_q)));

endmodule

// File: rtl/cmaint_engine.sv
module cmaint_engine
  import cme_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 16,
  parameter int NUM_SETS   = 128,
  parameter int NUM_WAYS   = 2,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int SET_W     = $clog2(NUM_SETS),
  localparam int WAY_W     = $clog2(NUM_WAYS),
  localparam int LA_W      = ADDR_W - OFF_W,
  localparam int TAG_W     = LA_W - SET_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             code_wr_i,
  input  logic [2:0]       code_wdata_i,
  input  logic             start_i,
  input  logic             finv_i,
  input  logic [LA_W-1:0]  rng_lo_i,
  input  logic [LA_W-1:0]  rng_hi_i,
  input  logic             tag_busy_i,
  input  logic             tag_rd_valid_i,
  input  logic             tag_rd_dirty_i,
  input  logic             tag_rd_priv_i,
  input  logic [TAG_W-1:0] tag_rd_tag_i,
  output logic             tag_acc_o,
  output logic [SET_W-1:0] tag_set_o,
  output logic [WAY_W-1:0] tag_way_o,
  output logic             tag_inv_o,
  output logic             tag_cln_o,
  output logic             wb_req_o,
  output logic [ADDR_W-1:0] wb_addr_o,
  output logic [WAY_W-1:0] wb_way_o,
  output logic             wb_priv_o,
  input  logic             wb_done_i,
  input  logic             wb_err_i,
  input  logic             evict_err_i,
  input  logic             clr_err_i,
  input  logic             clr_fend_i,
  input  logic             clr_cend_i,
  input  logic             ie_err_i,
  input  logic             ie_fend_i,
  input  logic             ie_cend_i,
  output logic [2:0]       code_o,
  output logic             full_busy_o,
  output logic             full_end_o,
  output logic             cmd_busy_o,
  output logic             cmd_end_o,
  output logic             err_o,
  output logic             irq_o
);

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [LA_W-1:0]  line_addr;
  logic             in_rng;
  logic [TAG_W-1:0] wb_tag;
  logic             fend_set, cend_set, err_set;
  logic [2:0]       code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign line_addr = {tag_rd_tag_i, tag_set_o};

  cme_range_match #(.LA_W(LA_W)) u_match (
    .lo_i     (rng_lo_i),
    .hi_i     (rng_hi_i),
    .line_i   (line_addr),
    .in_rng_o (in_rng)
  );

  cme_walk_ctrl #(.SET_W(SET_W), .WAY_W(WAY_W), .TAG_W(TAG_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .en_i        (en_i),
    .start_i     (start_i),
    .finv_i      (finv_i),
    .code_ok_i   (code_is_cmd(code_q)),
    .do_clean_i  (code_q[0]),
    .do_inv_i    (code_q[1]),
    .tag_busy_i  (tag_busy_i),
    .rd_valid_i  (tag_rd_valid_i),
    .rd_dirty_i  (tag_rd_dirty_i),
    .rd_priv_i   (tag_rd_priv_i),
    .rd_tag_i    (tag_rd_tag_i),
    .in_rng_i    (in_rng),
    .wb_done_i   (wb_done_i),
    .tag_acc_o   (tag_acc_o),
    .tag_inv_o   (tag_inv_o),
    .tag_cln_o   (tag_cln_o),
    .tag_set_o   (tag_set_o),
    .tag_way_o   (tag_way_o),
    .wb_req_o    (wb_req_o),
    .wb_tag_o    (wb_tag),
    .wb_priv_o   (wb_priv_o),
    .full_busy_o (full_busy_o),
    .cmd_busy_o  (cmd_busy_o),
    .fend_o      (fend_set),
    .cend_o      (cend_set)
  );

  assign err_set = (wb_req_o && wb_done_i && wb_err_i) || evict_err_i;

  cme_status u_status (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .code_wr_i    (code_wr_i),
    .code_wdata_i (code_wdata_i),
    .cmd_busy_i   (cmd_busy_o),
    .fend_set_i   (fend_set),
    .cend_set_i   (cend_set),
    .err_set_i    (err_set),
    .clr_err_i    (clr_err_i),
    .clr_fend_i   (clr_fend_i),
    .clr_cend_i   (clr_cend_i),
    .ie_err_i     (ie_err_i),
    .ie_fend_i    (ie_fend_i),
    .ie_cend_i    (ie_cend_i),
    .code_o       (code_q),
    .full_end_o   (full_end_o),
    .cmd_end_o    (cmd_end_o),
    .err_o        (err_o),
    .irq_o        (irq_o)
  );

  assign code_o    = code_q;
  assign wb_addr_o = {wb_tag, tag_set_o, {OFF_W{1'b0}}};
  assign wb_way_o  = tag_way_o;

  // R1: end of a full invalidate raises its end flag in the same cycle
  assert_fend_on_fall_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(full_busy_o) |-> full_end_o);

  // R8: end of a range walk raises the command end flag in the same cycle
  assert_cend_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(cmd_busy_o) |-> cmd_end_o);

endmodule

// File: tb/cmaint_engine_tb.sv
module cmaint_engine_tb;

  localparam int ADDR_W = 32;
  localparam int LINE_BYTES = 16;
  localparam int NUM_SETS = 8;
  localparam int NUM_WAYS = 2;
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int SET_W = $clog2(NUM_SETS);
  localparam int WAY_W = $clog2(NUM_WAYS);
  localparam int LA_W = ADDR_W - OFF_W;
  localparam int TAG_W = LA_W - SET_W;
  localparam int IDX_W = SET_W + WAY_W;
  localparam int NENT = NUM_SETS * NUM_WAYS;

  typedef struct packed {
    logic [2:0]      code;
    logic [LA_W-1:0] lo;
    logic [LA_W-1:0] hi;
    logic [1:0]      bm;
    logic [3:0]      seed;
    logic            werr;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VEC [NVEC] = '{
    '{3'b001, 28'd0,  28'd63, 2'd0, 4'd1, 1'b0},
    '{3'b010, 28'd10, 28'd40, 2'd1, 4'd2, 1'b0},
    '{3'b011, 28'd5,  28'd50, 2'd2, 4'd3, 1'b0},
    '{3'b001, 28'd16, 28'd31, 2'd1, 4'd4, 1'b1},
    '{3'b011, 28'd63, 28'd0,  2'd0, 4'd5, 1'b0},
    '{3'b010, 28'd0,  28'd0,  2'd2, 4'd6, 1'b0}
  };

  logic clk, rst_n, en, code_wr, start, finv;
  logic [2:0] code_wdata;
  logic [LA_W-1:0] rng_lo, rng_hi;
  logic tag_busy, rd_v, rd_d, rd_p;
  logic [TAG_W-1:0] rd_t;
  logic tag_acc, tag_inv, tag_cln, wb_req, wb_priv;
  logic [SET_W-1:0] tag_set;
  logic [WAY_W-1:0] tag_way, wb_way;
  logic [ADDR_W-1:0] wb_addr;
  logic wb_done, wb_err, evict_err;
  logic clr_err, clr_fend, clr_cend, ie_err, ie_fend, ie_cend;
  logic [2:0] code_q;
  logic full_busy, full_end, cmd_busy, cmd_end, err, irq;

  cmaint_engine #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .NUM_SETS(NUM_SETS),
                  .NUM_WAYS(NUM_WAYS)) u_dut (
    .clk(clk), .rst_n(rst_n), .en_i(en), .code_wr_i(code_wr), .code_wdata_i(code_wdata),
    .start_i(start), .finv_i(finv), .rng_lo_i(rng_lo), .rng_hi_i(rng_hi),
    .tag_busy_i(tag_busy), .tag_rd_valid_i(rd_v), .tag_rd_dirty_i(rd_d),
    .tag_rd_priv_i(rd_p), .tag_rd_tag_i(rd_t), .tag_acc_o(tag_acc), .tag_set_o(tag_set),
    .tag_way_o(tag_way), .tag_inv_o(tag_inv), .tag_cln_o(tag_cln), .wb_req_o(wb_req),
    .wb_addr_o(wb_addr), .wb_way_o(wb_way), .wb_priv_o(wb_priv), .wb_done_i(wb_done),
    .wb_err_i(wb_err), .evict_err_i(evict_err), .clr_err_i(clr_err), .clr_fend_i(clr_fend),
    .clr_cend_i(clr_cend), .ie_err_i(ie_err), .ie_fend_i(ie_fend), .ie_cend_i(ie_cend),
    .code_o(code_q), .full_busy_o(full_busy), .full_end_o(full_end),
    .cmd_busy_o(cmd_busy), .cmd_end_o(cmd_end), .err_o(err), .irq_o(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // tag contents generator
  function automatic logic gv(int e, int s); return ((e * 7 + s) % 4) != 0; endfunction
  function automatic logic gd(int e, int s); return ((e * 5 + s) % 3) != 2; endfunction
  function automatic logic gp(int e, int s); return ((e + s) % 2) == 1; endfunction
  function automatic logic [TAG_W-1:0] gt(int e, int s);
    return TAG_W'((e * 3 + s * 5) % 8);
  endfunction
  function automatic logic [LA_W-1:0] gla(int e, int s);
    return LA_W'(int'(gt(e, s)) * NUM_SETS + e / NUM_WAYS);
  endfunction

  // tag memory model
  logic m_v [NENT];
  logic m_d [NENT];
  logic m_p [NENT];
  logic [TAG_W-1:0] m_t [NENT];
  logic load_req;
  int   load_seed;
  logic [IDX_W-1:0] cur_idx;
  assign cur_idx = {tag_set, tag_way};
  assign rd_v = m_v[cur_idx];
  assign rd_d = m_d[cur_idx];
  assign rd_p = m_p[cur_idx];
  assign rd_t = m_t[cur_idx];

  always @(posedge clk) begin
    if (load_req) begin
      for (int e = 0; e < NENT; e++) begin
        m_v[e] <= gv(e, load_seed);
        m_d[e] <= gd(e, load_seed);
        m_p[e] <= gp(e, load_seed);
        m_t[e] <= gt(e, load_seed);
      end
    end else if (tag_acc) begin
      if (tag_inv) begin
        m_v[cur_idx] <= 1'b0;
        m_d[cur_idx] <= 1'b0;
        m_p[cur_idx] <= 1'b0;
      end else if (tag_cln) begin
        m_d[cur_idx] <= 1'b0;
      end
    end
  end

  // traffic pattern on the tag port
  logic [1:0] busy_mode;
  logic [7:0] tcyc;
  always @(posedge clk) tcyc <= tcyc + 8'd1;
  initial tcyc = 8'd0;
  assign tag_busy = (busy_mode == 2'd1) ? tcyc[0] :
                    (busy_mode == 2'd2) ? (tcyc[1:0] != 2'b00) : 1'b0;

  // write-back responder with its own checks against the generator
  logic werr_mode;
  logic [2:0] cur_code;
  logic [LA_W-1:0] cur_lo, cur_hi;
  logic pend;
  int   wdly, wb_seen, wb_bad;
  always @(posedge clk) begin
    if (!rst_n || load_req) begin
      pend <= 1'b0; wdly <= 0; wb_done <= 1'b0; wb_err <= 1'b0;
      wb_seen <= 0; wb_bad <= 0;
    end else begin
      wb_done <= 1'b0;
      wb_err  <= 1'b0;
      if (wb_req && !wb_done && !pend) begin
        int e;
        logic [LA_W-1:0] la;
        pend <= 1'b1;
        wdly <= 3;
        wb_seen <= wb_seen + 1;
        e  = int'(wb_addr[OFF_W +: SET_W]) * NUM_WAYS + int'(wb_way);
        la = wb_addr[ADDR_W-1:OFF_W];
        if (!(gv(e, load_seed) && gd(e, load_seed) && cur_code[0] &&
              la >= cur_lo && la <= cur_hi && la == gla(e, load_seed) &&
              wb_priv == gp(e, load_seed) && wb_addr[OFF_W-1:0] == '0))
          wb_bad <= wb_bad + 1;
      end else if (pend) begin
        if (wdly == 1) begin
          wb_done <= 1'b1;
          wb_err  <= werr_mode;
          pend    <= 1'b0;
        end
        wdly <= wdly - 1;
      end
    end
  end

  // monitors for yielding and for the write-back wait
  int yield_viol, wait_viol;
  initial begin yield_viol = 0; wait_viol = 0; end
  always @(negedge clk) begin
    if (cmd_busy && tag_busy && tag_acc) yield_viol <= yield_viol + 1;
    if (wb_req && tag_acc) wait_viol <= wait_viol + 1;
  end

  int total, bad;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  int wd;
  initial wd = 0;
  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd > 150000) begin
      $display("FAIL watchdog act=%0d exp=%0d", wd, 150000);
      $display("  test done: total=%0d bad=%0d", total + 1, bad + 1);
      $finish;
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic wait_idle();
    for (int k = 0; k < 5000; k++) begin
      if (!cmd_busy && !full_busy) break;
      tick();
    end
  endtask

  task automatic load(input int s);
    load_seed = s; load_req = 1'b1; tick(); load_req = 1'b0;
  endtask

  task automatic count_valid(output int n);
    n = 0;
    for (int e = 0; e < NENT; e++) if (m_v[e]) n++;
  endtask

  initial begin
    int n, ewb, mis;
    bit any_err;
    total = 0; bad = 0;
    rst_n = 1'b0; en = 1'b0; code_wr = 1'b0; code_wdata = 3'b000; start = 1'b0; finv = 1'b0;
    rng_lo = '0; rng_hi = '0; evict_err = 1'b0; clr_err = 1'b0; clr_fend = 1'b0;
    clr_cend = 1'b0; ie_err = 1'b0; ie_fend = 1'b0; ie_cend = 1'b0;
    busy_mode = 2'd0; werr_mode = 1'b0; cur_code = 3'b000; cur_lo = '0; cur_hi = '0;
    load_seed = 9; load_req = 1'b1;
    repeat (3) tick();
    load_req = 1'b0;
    tick();
    rst_n = 1'b1;
    tick();
    // R1: reset state, full invalidate running
    chk(full_busy == 1'b1, "R1 busy after reset", full_busy, 1);
    chk(cmd_busy == 1'b0 && code_q == 3'b000 && err == 1'b0, "R1 reset flags",
        {cmd_busy, code_q, err}, 0);
    wait_idle();
    count_valid(n);
    chk(n == 0, "R1 all invalid", n, 0);
    chk(full_end == 1'b1 && full_busy == 1'b0, "R1 end flag", {full_busy, full_end}, 1);
    chk(irq == 1'b0, "R11 irq masked", irq, 0);
    // R11: enable and clear of busy-end
    ie_fend = 1'b1; tick();
    chk(irq == 1'b1, "R11 irq fend", irq, 1);
    clr_fend = 1'b1; tick(); clr_fend = 1'b0; tick();
    chk(full_end == 1'b0 && irq == 1'b0, "R11 clear fend", {full_end, irq}, 0);
    ie_fend = 1'b0;

    // R2: rejected starts
    code_wdata = 3'b001; code_wr = 1'b1; tick(); code_wr = 1'b0;
    start = 1'b1; tick(); start = 1'b0;
    chk(cmd_busy == 1'b0, "R2 start while disabled", cmd_busy, 0);
    en = 1'b1;
    for (int c = 0; c < 8; c++) begin
      if (c >= 1 && c <= 3) continue;
      code_wdata = 3'(c); code_wr = 1'b1; tick(); code_wr = 1'b0;
      start = 1'b1; tick(); start = 1'b0;
      chk(cmd_busy == 1'b0 && code_q == 3'(c), "R2 start with no-op or reserved code",
          cmd_busy, 0);
    end

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      busy_mode = VEC[i].bm; werr_mode = VEC[i].werr;
      cur_code = VEC[i].code; cur_lo = VEC[i].lo; cur_hi = VEC[i].hi;
      load(int'(VEC[i].seed));
      clr_err = 1'b1; clr_cend = 1'b1; tick(); clr_err = 1'b0; clr_cend = 1'b0;
      rng_lo = VEC[i].lo; rng_hi = VEC[i].hi;
      code_wdata = VEC[i].code; code_wr = 1'b1; tick(); code_wr = 1'b0;
      start = 1'b1; tick(); start = 1'b0;
      chk(cmd_busy == 1'b1, "R2 start accepted", cmd_busy, 1);
      wait_idle();
      chk(cmd_end == 1'b1 && cmd_busy == 1'b0, "R8 command end", {cmd_busy, cmd_end}, 1);
      ewb = 0; mis = 0;
      for (int e = 0; e < NENT; e++) begin
        logic v0, d0, p0, h, ev, ed, ep;
        logic [LA_W-1:0] la;
        v0 = gv(e, int'(VEC[i].seed)); d0 = gd(e, int'(VEC[i].seed));
        p0 = gp(e, int'(VEC[i].seed)); la = gla(e, int'(VEC[i].seed));
        h  = v0 && la >= VEC[i].lo && la <= VEC[i].hi;
        if (h && VEC[i].code[0] && d0) ewb++;
        ev = v0 && !(h && VEC[i].code[1]);
        ed = d0 && !h;
        ep = p0 && !(h && VEC[i].code[1]);
        if (h && !VEC[i].code[0] && !VEC[i].code[1]) ed = d0;
        if (m_v[e] != ev || m_d[e] != ed || m_p[e] != ep) mis++;
      end
      case (VEC[i].code)
        3'b001:  chk(mis == 0, "R4 clean final tags", mis, 0);
        3'b010:  chk(mis == 0, "R5 invalidate final tags", mis, 0);
        default: chk(mis == 0, "R6 clean-invalidate final tags", mis, 0);
      endcase
      chk(VEC[i].lo <= VEC[i].hi || ewb == 0, "R3 empty range", ewb, 0);
      chk(wb_seen == ewb, "R4 write-back count", wb_seen, ewb);
      chk(wb_bad == 0, "R3 write-back address and attributes", wb_bad, 0);
      chk(yield_viol == 0, "R7 yield to traffic", yield_viol, 0);
      chk(wait_viol == 0, "R13 no access while waiting", wait_viol, 0);
      any_err = VEC[i].werr && (ewb > 0);
      chk(err == any_err, "R10 write-back error flag", err, any_err);
    end

    // R11: command-end interrupt and clear
    ie_cend = 1'b1; tick();
    chk(irq == 1'b1, "R11 irq cend", irq, 1);
    clr_cend = 1'b1; tick(); clr_cend = 1'b0; ie_cend = 1'b0;
    chk(cmd_end == 1'b0, "R11 clear cend", cmd_end, 0);

    // R12: code write while busy is ignored
    busy_mode = 2'd2; werr_mode = 1'b0;
    cur_code = 3'b001; cur_lo = '0; cur_hi = '1;
    load(11);
    rng_lo = '0; rng_hi = '1;
    code_wdata = 3'b001; code_wr = 1'b1; tick(); code_wr = 1'b0;
    start = 1'b1; tick(); start = 1'b0;
    code_wdata = 3'b010; code_wr = 1'b1; tick(); code_wr = 1'b0; tick();
    chk(code_q == 3'b001, "R12 code write ignored while busy", code_q, 1);
    wait_idle();
    chk(code_q == 3'b001, "R12 code held to the end", code_q, 1);
    code_wr = 1'b1; tick(); code_wr = 1'b0;
    chk(code_q == 3'b010, "R12 code write when idle", code_q, 2);

    // R9: software full invalidate, start rejected while it runs
    busy_mode = 2'd1;
    load(12);
    finv = 1'b1; tick(); finv = 1'b0;
    chk(full_busy == 1'b1, "R9 full invalidate starts", full_busy, 1);
    start = 1'b1; tick(); start = 1'b0;
    chk(cmd_busy == 1'b0, "R2 start rejected during full invalidate", cmd_busy, 0);
    wait_idle();
    count_valid(n);
    chk(n == 0 && full_end == 1'b1, "R9 full invalidate clears all", n, 0);

    // R10 / R11: eviction error path
    evict_err = 1'b1; tick(); evict_err = 1'b0;
    chk(err == 1'b1 && irq == 1'b0, "R10 evict error flag", {err, irq}, 2);
    ie_err = 1'b1; tick();
    chk(irq == 1'b1, "R11 irq err", irq, 1);
    clr_err = 1'b1; tick(); clr_err = 1'b0;
    chk(err == 1'b0 && irq == 1'b0, "R11 clear err", {err, irq}, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule